// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block decodes a card-to-reader reply whose length the reader already knows. The reply carries no start marker, no stop marker and no length field. The input is one digital line: the received envelope after a hysteresis comparator. A one is sent as a burst of subcarrier toggles, and a zero is sent as a quiet line. The block does not sample a level. It counts every transition of the line inside fixed-length bit windows and compares the count with an acceptance band.

A one-cycle `start_i` pulse marks the end of the reader frame. On that pulse the block latches three things: the requested bit count, the decryption enable and a keystream word prepared beforehand. It then waits a fixed settling interval. After that it runs back-to-back bit windows, one per requested bit, and builds the reply word least significant bit first. When the last window closes, the block presents the word with a one-cycle valid strobe. Its internal timer restarts at that point, so the next frame can be timed from there.

A reply of all zeros looks exactly like an absent card. The block reports such a reply as a zero word and raises no flag for it.

Top module: `edge_count_rx`

## Requirements
- R1: After reset, `data_o` is zero and `valid_o` is low.
- R2: `valid_o` pulses high for exactly one cycle. It becomes visible WAIT_TICKS + BIT_TICKS·n clock edges after the edge that samples `start_i`, where n is the clamped bit count. With the defaults that is 490 + 150·n edges.
- R3: A window decodes as 1 only when its edge count is strictly above EDGE_LO (20) and strictly below EDGE_HI (60). Counts of 20 and 60 decode as 0. Counts of 21, 42 and 59 decode as 1.
- R4: Every level change of `rx_level_i` counts as one edge, whether it rises or falls.
- R5: The per-window edge count saturates at CNT_SAT (63). Because of this, 85 edges decode as 0 and do not wrap into the band.
- R6: A requested count above MAX_BITS (32) is clamped to MAX_BITS. Both the number of windows and the timing follow the clamped value.
- R7: Bit j of `data_o` holds window j, least significant first. Bits at or above n are zero.
- R8: With `decrypt_en_i` high, each decoded bit is XORed with the matching bit of `keystream_i` as sampled with `start_i`. Later changes to `keystream_i` have no effect on the frame in progress.
- R9: With `decrypt_en_i` low, `keystream_i` has no effect on `data_o`.
- R10: A `start_i` pulse while a frame is in progress is ignored. The running frame keeps its length and timing.
- R11: After the last window the block returns to idle with its timer cleared. A `start_i` pulse in the same cycle as `valid_o` begins the next frame.
- R12: A requested count of 0 produces `valid_o` WAIT_TICKS edges after start, with `data_o` equal to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock; one cycle is one timing tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | End of the reader frame; starts reception when the block is idle |
| req_bits_i | input | REQ_W (6) | Number of reply bits requested, sampled with start_i |
| decrypt_en_i | input | 1 | Apply the keystream to the decoded bits, sampled with start_i |
| keystream_i | input | MAX_BITS (32) | Precomputed keystream word, sampled with start_i |
| rx_level_i | input | 1 | Asynchronous hysteresis-filtered envelope level |
| data_o | output | MAX_BITS (32) | Decoded reply word, held until the next frame completes |
| valid_o | output | 1 | One-cycle strobe when data_o is updated |

## Verification
A frame's only result is the valid strobe with its word. That result is due exactly 490 + 150·n edges after the start edge, with 490 edges for an empty request. The driver computes this edge from the bench's own cycle count and queues it together with the expected word. The monitor pops the queue when the strobe appears and compares both the cycle and the data. Input toggles fall 10 ticks inside each window, so the three-register path from the line to the counter keeps every edge inside its intended window. The bench starts back-to-back frames in the same cycle as the previous strobe, which checks the return to idle.

// File: rtl/edge_rx_pkg.sv
package edge_rx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_BITS = 2'd2
  } rx_state_e;

  // Limit a requested length to the word width.
  function automatic int clamp_len(int req, int max_bits);
    return (req > max_bits) ? max_bits : req;
  endfunction

  // Window decision: strictly inside the open band (lo, hi).
  function automatic logic in_band(int cnt, int lo, int hi);
    return (cnt > lo) && (cnt < hi);
  endfunction

  // Saturating accumulate.
  function automatic int sat_add(int cnt, int inc, int sat);
    return (cnt + inc > sat) ? sat : cnt + inc;
  endfunction

  // Mask with the n lowest bits set.
  function automatic logic [63:0] low_ones(int n);
    if (n <= 0) return 64'd0;
    if (n >= 64) return {64{1'b1}};
    return (64'd1 << n) - 64'd1;
  endfunction

endpackage

// File: rtl/rx_edge_sync.sv
module rx_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic edge_o
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  logic [PIPE_W-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[PIPE_W-2:0], async_i};
  end

  // Any change between the last synchronised level and the one before.
  assign edge_o = pipe_q[PIPE_W-1] ^ pipe_q[PIPE_W-2];
endmodule

// File: rtl/window_edge_counter.sv
module window_edge_counter
  import edge_rx_pkg::*;
#(
  parameter int CNT_SAT = 63,
  localparam int CNT_W  = $clog2(CNT_SAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             edge_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_now_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             inc;

  assign inc       = en_i & edge_i;
  assign cnt_now_o = CNT_W'(sat_add(int'(cnt_q), int'(inc), CNT_SAT));
  assign cnt_q_o   = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_now_o;
  end
endmodule

// File: rtl/edge_count_rx.sv
module edge_count_rx
  import edge_rx_pkg::*;
#(
  parameter int WAIT_TICKS  = 490,
  parameter int BIT_TICKS   = 150,
  parameter int MAX_BITS    = 32,
  parameter int EDGE_LO     = 20,
  parameter int EDGE_HI     = 60,
  parameter int CNT_SAT     = 63,
  parameter int REQ_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [REQ_W-1:0]    req_bits_i,
  input  logic                decrypt_en_i,
  input  logic [MAX_BITS-1:0] keystream_i,
  input  logic                rx_level_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                valid_o
);
  localparam int TMR_MAX = (WAIT_TICKS > BIT_TICKS) ? WAIT_TICKS : BIT_TICKS;
  localparam int TMR_W   = $clog2(TMR_MAX + 1);
  localparam int CNT_W   = $clog2(CNT_SAT + 1);
  localparam int IDX_W   = $clog2(MAX_BITS + 1);

  rx_state_e           state_q;
  logic [TMR_W-1:0]    tmr_q;
  logic [IDX_W-1:0]    idx_q;
  logic [IDX_W-1:0]    len_q;
  logic [MAX_BITS-1:0] acc_q;
  logic [MAX_BITS-1:0] data_q;
  logic                valid_q;

  // Named internal events, also used by the checker.
  logic                edge_pulse;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    cnt_now;
  logic                busy_w;
  logic                count_en_w;
  logic                accept_start;
  logic                wait_done;
  logic                win_end;
  logic                last_win;
  logic                frame_done;
  logic                win_bit;
  logic [IDX_W-1:0]    start_len;
  logic [63:0]         start_mask_w;
  logic [MAX_BITS-1:0] acc_flip;
  logic [MAX_BITS-1:0] acc_next;

  rx_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (rx_level_i),
    .edge_o  (edge_pulse)
  );

  window_edge_counter #(.CNT_SAT(CNT_SAT)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (count_en_w),
    .edge_i    (edge_pulse),
    .clr_i     (win_end),
    .cnt_q_o   (cnt_q),
    .cnt_now_o (cnt_now)
  );

  assign busy_w       = (state_q != ST_IDLE);
  assign count_en_w   = (state_q == ST_BITS);
  assign accept_start = (state_q == ST_IDLE) && start_i;
  assign wait_done    = (state_q == ST_WAIT) && (tmr_q == TMR_W'(WAIT_TICKS - 1));
  assign win_end      = (state_q == ST_BITS) && (tmr_q == TMR_W'(BIT_TICKS - 1));
  assign last_win     = win_end && (IDX_W'(idx_q + 1'b1) == len_q);
  assign frame_done   = (wait_done && (len_q == '0)) || last_win;
  assign win_bit      = in_band(int'(cnt_now), EDGE_LO, EDGE_HI);
  assign start_len    = IDX_W'(clamp_len(int'(req_bits_i), MAX_BITS));
  assign start_mask_w = low_ones(int'(start_len));
  assign acc_flip     = (win_end && win_bit) ? (MAX_BITS'(1) << idx_q) : '0;
  assign acc_next     = acc_q ^ acc_flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      idx_q   <= '0;
      len_q   <= '0;
      acc_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_start) begin
            len_q   <= start_len;
            acc_q   <= decrypt_en_i ? (keystream_i & start_mask_w[MAX_BITS-1:0]) : '0;
            tmr_q   <= '0;
            idx_q   <= '0;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (wait_done) begin
            tmr_q   <= '0;
            state_q <= (len_q == '0) ? ST_IDLE : ST_BITS;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        ST_BITS: begin
          if (win_end) begin
            tmr_q <= '0;
            acc_q <= acc_next;
            if (last_win) state_q <= ST_IDLE;
            else          idx_q   <= idx_q + 1'b1;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= frame_done;
      if (frame_done) data_q <= acc_next;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/edge_count_rx_chk.sv
module edge_count_rx_chk
  import edge_rx_pkg::*;
#(
  parameter int MAX_BITS = 32,
  parameter int CNT_SAT  = 63,
  parameter int IDX_W    = 6,
  parameter int CNT_W    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start_i,
  input logic                valid_o,
  input logic [MAX_BITS-1:0] data_o,
  input logic                busy_w,
  input logic                count_en_w,
  input logic                edge_pulse,
  input logic                win_end,
  input logic [CNT_W-1:0]    cnt_q,
  input logic [IDX_W-1:0]    len_q
);
  logic [63:0] len_mask;
  assign len_mask = low_ones(int'(len_q));

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R2
  AST_VALID_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(busy_w)); // R2
  AST_LEN_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> (int'(len_q) <= MAX_BITS)); // R6
  AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((data_o & ~len_mask[MAX_BITS-1:0]) == '0)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_w && start_i) |=> $stable(len_q)); // R10
  AST_EDGE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en_w && edge_pulse && !win_end && cnt_q < CNT_W'(CNT_SAT))
      |=> (cnt_q == $past(cnt_q) + 1'b1)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en_w && edge_pulse && !win_end && cnt_q == CNT_W'(CNT_SAT))
      |=> (cnt_q == CNT_W'(CNT_SAT))); // R5
endmodule

bind edge_count_rx edge_count_rx_chk #(
  .MAX_BITS (MAX_BITS),
  .CNT_SAT  (CNT_SAT),
  .IDX_W    (IDX_W),
  .CNT_W    (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .valid_o    (valid_o),
  .data_o     (data_o),
  .busy_w     (busy_w),
  .count_en_w (count_en_w),
  .edge_pulse (edge_pulse),
  .win_end    (win_end),
  .cnt_q      (cnt_q),
  .len_q      (len_q)
);

// File: tb/tb_edge_count_rx.sv
module tb_edge_count_rx;
  localparam int CLK_PERIOD = 10;
  localparam int WAIT_T = 490;
  localparam int BIT_T  = 150;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [5:0]  req_bits_i = '0;
  logic        decrypt_en_i = 1'b0;
  logic [31:0] keystream_i = '0;
  logic        rx_level_i = 1'b0;
  logic [31:0] data_o;
  logic        valid_o;

  edge_count_rx dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .req_bits_i   (req_bits_i),
    .decrypt_en_i (decrypt_en_i),
    .keystream_i  (keystream_i),
    .rx_level_i   (rx_level_i),
    .data_o       (data_o),
    .valid_o      (valid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int win_cnt [32];

  logic [31:0] q_data [$];
  int          q_cyc  [$];
  string       q_tag  [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Monitor: pops expected results as strobes appear.
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (valid_o && prev_valid) check(1'b0, "R2 single-cycle strobe", 1, 0);
      if (valid_o) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R2 unexpected strobe", 1, 0);
        end else begin
          logic [31:0] ed;
          int          ec;
          string       et;
          ed = q_data.pop_front();
          ec = q_cyc.pop_front();
          et = q_tag.pop_front();
          check(data_o == ed, {et, " data"}, data_o, ed);
          check(cyc == ec, {et, " R2 strobe cycle"}, cyc, ec);
        end
      end
      prev_valid <= valid_o;
    end
  end

  // Driver: called at a negative edge; returns at the strobe's negative edge.
  task automatic run_frame(int req, bit crypt, logic [31:0] ks, bit inject, string tag);
    int n;
    int t;
    int eff;
    logic [31:0] mask;
    logic [31:0] exp;
    n = (req > 32) ? 32 : req;
    mask = (n >= 32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    exp = crypt ? (ks & mask) : 32'd0;
    for (int j = 0; j < n; j++) begin
      eff = (win_cnt[j] > 63) ? 63 : win_cnt[j];
      if (eff > 20 && eff < 60) exp[j] = ~exp[j];
    end
    q_data.push_back(exp);
    q_cyc.push_back(cyc + 1 + WAIT_T + BIT_T * n);
    q_tag.push_back(tag);
    start_i = 1'b1;
    req_bits_i = req[5:0];
    decrypt_en_i = crypt;
    keystream_i = ks;
    @(negedge clk);
    start_i = 1'b0;
    keystream_i = ~ks;          // R8: later keystream changes must not matter
    req_bits_i = 6'd1;
    t = 0;
    for (int j = 0; j < n; j++) begin
      while (t < WAIT_T + BIT_T * j + 10) begin
        @(negedge clk);
        t++;
        start_i = inject && (t == 300); // R10: start while busy
      end
      for (int m = 0; m < win_cnt[j]; m++) begin
        rx_level_i = ~rx_level_i;
        @(negedge clk);
        t++;
      end
    end
    while (t < WAIT_T + BIT_T * n) begin
      @(negedge clk);
      t++;
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(data_o == 32'd0, "R1 data after reset", data_o, 0);
    check(valid_o == 1'b0, "R1 valid after reset", valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 band edges, R4 both directions, R5 saturation, R7 bit order
    win_cnt[0] = 0;  win_cnt[1] = 20; win_cnt[2] = 21; win_cnt[3] = 42;
    win_cnt[4] = 59; win_cnt[5] = 60; win_cnt[6] = 85; win_cnt[7] = 30;
    run_frame(8, 1'b0, 32'h0, 1'b0, "R3/R4/R5/R7");

    // R8 decryption, started back to back
    win_cnt[0] = 42; win_cnt[1] = 0; win_cnt[2] = 42; win_cnt[3] = 0;
    win_cnt[4] = 0;  win_cnt[5] = 0; win_cnt[6] = 0;  win_cnt[7] = 42;
    run_frame(8, 1'b1, 32'hA5A5_A5A5, 1'b0, "R8");

    // R9 keystream ignored without decryption, R11 back to back
    for (int j = 0; j < 5; j++) win_cnt[j] = 42;
    run_frame(5, 1'b0, 32'hFFFF_FFFF, 1'b0, "R9/R11");

    // R6 clamp from 40 to 32, R10 ignored start
    for (int j = 0; j < 32; j++) win_cnt[j] = (j % 3 == 0) ? 42 : 0;
    @(negedge clk);
    run_frame(40, 1'b0, 32'h0, 1'b1, "R6/R10");

    // R12 empty request
    @(negedge clk);
    run_frame(0, 1'b1, 32'hFFFF_FFFF, 1'b0, "R12");

    // R8 single bit cancelled by keystream
    win_cnt[0] = 42;
    run_frame(1, 1'b1, 32'h0000_0003, 1'b0, "R8");

    repeat (4) @(negedge clk);
    check(q_data.size() == 0, "R2 all strobes seen", q_data.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule